// File: doc/BRIEF.md
# Addressed Serial Frame Dispatcher

This block sits behind a serial frame decoder on a multi-drop display node. Each time the decoder finishes a frame, it strobes `frame_done` and presents the payload length and the first four payload bytes. The block works out what kind of frame it is from the length alone and acts on it. A frame with no payload is a discovery probe. A four-byte frame selects a node by identifier. A one-byte frame is a command. A frame of half the framebuffer size is a picture-data half. Any other length is malformed.

A node must first be selected by an address frame that carries its own identifier. It then accepts exactly one command and drops back to the unselected state. Replies are not encoded here. The block raises a one-cycle request to the reply path: either "send identifier" or "send status record". It also offers the status record as a flat bus that the reply path serialises. Malformed or out-of-turn frames pulse an error output and bump a saturating error counter. Every completed frame pulses an activity output.

Top module: `serial_frame_dispatcher`

## Requirements
- R1: While reset is active, and until the first frame after its release, the node is unselected and all pulse outputs and `bad_frames` are zero.
- R2: Each `frame_done` strobe produces exactly one cycle of `act_pulse`, in the cycle after the strobe.
- R3: A zero-length frame raises `send_id` in the next cycle only while fewer than `BOOT_WINDOW_MS` `ms_tick` pulses have been seen since reset. Once the window has closed, the frame produces no reply and no error.
- R4: A frame of `ID_BYTES` (4) bytes selects the node when `payload_word` equals `dev_id`. Any other value leaves the node unselected.
- R5: A one-byte frame arriving while the node is selected raises `send_status` in the next cycle when byte 0 (`payload_word[7:0]`) equals `CMD_STATUS` (0x01). Any other command byte produces no reply and no error.
- R6: A one-byte frame arriving while the node is not selected pulses `err_pulse` and increments `bad_frames`.
- R7: After any one-byte frame the node is unselected, so each address frame arms exactly one command.
- R8: A frame of `HALF_FB_BYTES` bytes unselects the node and raises neither a reply nor an error.
- R9: A frame of any length other than 0, 1, `ID_BYTES` or `HALF_FB_BYTES` pulses `err_pulse`, increments `bad_frames` and unselects the node.
- R10: A reply that would be requested while `reply_busy` is high is dropped, but the frame still updates the node state. `send_id` and `send_status` are never high together.
- R11: `bad_frames` is `CNT_W` bits wide and stays at its all-ones value instead of wrapping.
- R12: The 168-bit `status_rec` holds the following fields, from MSB down: firmware version [167:160], hardware version [159:152], zero pad [151:136], uptime seconds [135:104], brightness [103:96], milli-frames per second [95:64], overrun count [63:32] and invalid-frame count [31:0]. The rate field is 10^9 / `frame_dur_us`, and 0 when the duration is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe: a decoded frame is complete |
| frame_len | input | LEN_W | Payload byte count of the completed frame |
| payload_word | input | 32 | First four payload bytes, byte 0 in [7:0] |
| dev_id | input | 32 | This node's identifier |
| ms_tick | input | 1 | One pulse per elapsed millisecond |
| reply_busy | input | 1 | Reply path cannot take a request |
| fw_version | input | 8 | Firmware version for the status record |
| hw_version | input | 8 | Hardware version for the status record |
| uptime_s | input | 32 | Uptime in seconds |
| brightness | input | 8 | Global brightness |
| frame_dur_us | input | 32 | Display frame duration in microseconds |
| overruns | input | 32 | Receiver overrun count |
| send_id | output | 1 | Request: transmit the identifier |
| send_status | output | 1 | Request: transmit the status record |
| err_pulse | output | 1 | One-cycle error indication |
| act_pulse | output | 1 | One-cycle activity indication |
| bad_frames | output | CNT_W | Saturating invalid-frame counter |
| status_rec | output | 168 | Assembled status record |

## Verification
A vector table replays frame sequences that differ only in the order of address and command frames. This separates a node that re-arms wrongly from one that stays armed after a command. Matching and mismatching identifiers, a command byte other than 0x01, and a half-framebuffer frame arriving both armed and unarmed show that only the exact sequence address → status command produces a reply. Busy-during-frame vectors show that the state still advances while the reply is dropped. Directed runs close the boot window with ticks, drive the counter into saturation, and vary the frame duration to expose the zero-duration rate case.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  typedef enum logic {
    NODE_IDLE  = 1'b0,
    NODE_ARMED = 1'b1
  } node_state_e;

  typedef enum logic [2:0] {
    FK_DISCOVER,
    FK_COMMAND,
    FK_ADDRESS,
    FK_HALFBUF,
    FK_MALFORMED
  } frame_kind_e;

  localparam int unsigned REC_W = 168;
endpackage

// File: rtl/sfd_boot_window.sv
module sfd_boot_window #(
  parameter int unsigned WINDOW_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  output logic open
);
  localparam int unsigned CW = $clog2(WINDOW_MS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW_MS);

  logic [CW-1:0] ms_q, ms_d;
  logic          ms_en;

  assign ms_en = ms_tick && (ms_q != LIMIT);

  always_comb begin
    ms_d = ms_q;
    if (ms_en) ms_d = ms_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ms_q <= '0;
    else        ms_q <= ms_d;
  end

  assign open = (ms_q < LIMIT);

  assert_window_stays_shut_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> !open);
endmodule

// File: rtl/sfd_sat_counter.sv
module sfd_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = inc && (cnt_q != TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP) |=> (cnt_q == TOP));
  assert_step_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != TOP) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/sfd_status_pack.sv
module sfd_status_pack
  import sfd_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic [7:0]       fw_version,
  input  logic [7:0]       hw_version,
  input  logic [31:0]      uptime_s,
  input  logic [7:0]       brightness,
  input  logic [31:0]      frame_dur_us,
  input  logic [31:0]      overruns,
  input  logic [CNT_W-1:0] bad_frames,
  output logic [REC_W-1:0] record
);
  localparam logic [31:0] MILLI_PER_US = 32'd1_000_000_000;

  logic [31:0] rate_mfps;

  always_comb begin
    if (frame_dur_us == '0) rate_mfps = '0;
    else                    rate_mfps = MILLI_PER_US / frame_dur_us;
  end

  assign record = {fw_version, hw_version, 16'h0000, uptime_s,
                   brightness, rate_mfps, overruns, 32'(bad_frames)};

  always_comb begin
    assert_zero_dur_rate_R12: assert ((frame_dur_us != '0) || (record[95:64] == '0));
  end
endmodule

// File: rtl/serial_frame_dispatcher.sv
module serial_frame_dispatcher
  import sfd_pkg::*;
#(
  parameter int unsigned LEN_W         = 8,
  parameter int unsigned ID_BYTES      = 4,
  parameter int unsigned HALF_FB_BYTES = 48,
  parameter int unsigned BOOT_WINDOW_MS = 100,
  parameter int unsigned CNT_W         = 32,
  parameter logic [7:0]  CMD_STATUS    = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [31:0]      payload_word,
  input  logic [31:0]      dev_id,
  input  logic             ms_tick,
  input  logic             reply_busy,
  input  logic [7:0]       fw_version,
  input  logic [7:0]       hw_version,
  input  logic [31:0]      uptime_s,
  input  logic [7:0]       brightness,
  input  logic [31:0]      frame_dur_us,
  input  logic [31:0]      overruns,
  output logic             send_id,
  output logic             send_status,
  output logic             err_pulse,
  output logic             act_pulse,
  output logic [CNT_W-1:0] bad_frames,
  output logic [REC_W-1:0] status_rec
);
  localparam logic [LEN_W-1:0] LEN_ADDR = LEN_W'(ID_BYTES);
  localparam logic [LEN_W-1:0] LEN_HALF = LEN_W'(HALF_FB_BYTES);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic boot_open;

  sfd_boot_window #(.WINDOW_MS(BOOT_WINDOW_MS)) u_boot (
    .clk     (clk),
    .rst_n   (srst_n),
    .ms_tick (ms_tick),
    .open    (boot_open)
  );

  // Frame classification from length only
  frame_kind_e kind;

  always_comb begin
    if (frame_len == '0)           kind = FK_DISCOVER;
    else if (frame_len == LEN_W'(1)) kind = FK_COMMAND;
    else if (frame_len == LEN_ADDR)  kind = FK_ADDRESS;
    else if (frame_len == LEN_HALF)  kind = FK_HALFBUF;
    else                             kind = FK_MALFORMED;
  end

  node_state_e state_q, state_d;
  logic        id_d, st_d, err_d, act_d;
  logic        id_q, st_q, err_q, act_q;

  always_comb begin
    state_d = state_q;
    id_d    = 1'b0;
    st_d    = 1'b0;
    err_d   = 1'b0;
    act_d   = 1'b0;
    if (frame_done) begin
      act_d = 1'b1;
      unique case (kind)
        FK_DISCOVER: id_d = boot_open && !reply_busy;
        FK_COMMAND: begin
          if (state_q == NODE_ARMED)
            st_d = (payload_word[7:0] == CMD_STATUS) && !reply_busy;
          else
            err_d = 1'b1;
          state_d = NODE_IDLE;
        end
        FK_ADDRESS: state_d = (payload_word == dev_id) ? NODE_ARMED : NODE_IDLE;
        FK_HALFBUF: state_d = NODE_IDLE;
        default: begin
          err_d   = 1'b1;
          state_d = NODE_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= NODE_IDLE;
      id_q    <= 1'b0;
      st_q    <= 1'b0;
      err_q   <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      id_q    <= id_d;
      st_q    <= st_d;
      err_q   <= err_d;
      act_q   <= act_d;
    end
  end

  sfd_sat_counter #(.W(CNT_W)) u_badcnt (
    .clk   (clk),
    .rst_n (srst_n),
    .inc   (err_d),
    .count (bad_frames)
  );

  sfd_status_pack #(.CNT_W(CNT_W)) u_pack (
    .fw_version   (fw_version),
    .hw_version   (hw_version),
    .uptime_s     (uptime_s),
    .brightness   (brightness),
    .frame_dur_us (frame_dur_us),
    .overruns     (overruns),
    .bad_frames   (bad_frames),
    .record       (status_rec)
  );

  assign send_id     = id_q;
  assign send_status = st_q;
  assign err_pulse   = err_q;
  assign act_pulse   = act_q;

  assert_act_follows_frame_R2: assert property (@(posedge clk) disable iff (!srst_n)
    frame_done |=> act_pulse);
  assert_status_needs_arm_R5: assert property (@(posedge clk) disable iff (!srst_n)
    frame_done && (kind == FK_COMMAND) && (state_q != NODE_ARMED) |=> !send_status && err_pulse);
  assert_cmd_disarms_R7: assert property (@(posedge clk) disable iff (!srst_n)
    frame_done && (kind == FK_COMMAND) |=> (state_q == NODE_IDLE));
  assert_malformed_disarms_R9: assert property (@(posedge clk) disable iff (!srst_n)
    frame_done && (kind == FK_MALFORMED) |=> (state_q == NODE_IDLE) && err_pulse);
  assert_busy_drops_reply_R10: assert property (@(posedge clk) disable iff (!srst_n)
    frame_done && reply_busy |=> !send_id && !send_status);
  assert_single_reply_R10: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({send_id, send_status}));
endmodule

// File: tb/serial_frame_dispatcher_tb.sv
module serial_frame_dispatcher_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;
  localparam int HALF = 48;
  localparam logic [31:0] MY_ID = 32'hC0FF_EE42;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_done;
  logic [7:0]  frame_len;
  logic [31:0] payload_word;
  logic        ms_tick, reply_busy;
  logic [7:0]  fw_version, hw_version, brightness;
  logic [31:0] uptime_s, frame_dur_us, overruns;
  logic        send_id, send_status, err_pulse, act_pulse;
  logic [CNT_W-1:0] bad_frames;
  logic [167:0] status_rec;

  int n_checks = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_frame_dispatcher #(.HALF_FB_BYTES(HALF), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_len(frame_len),
    .payload_word(payload_word), .dev_id(MY_ID), .ms_tick(ms_tick),
    .reply_busy(reply_busy), .fw_version(fw_version), .hw_version(hw_version),
    .uptime_s(uptime_s), .brightness(brightness), .frame_dur_us(frame_dur_us),
    .overruns(overruns), .send_id(send_id), .send_status(send_status),
    .err_pulse(err_pulse), .act_pulse(act_pulse), .bad_frames(bad_frames),
    .status_rec(status_rec));

  // {len, word, busy, exp_id, exp_status, exp_err}
  localparam int NV = 21;
  localparam logic [43:0] VEC [NV] = '{
    {8'd0,  32'h0,    1'b0, 3'b100},  // R3 discovery in window
    {8'd0,  32'h0,    1'b1, 3'b000},  // R10 busy drops id
    {8'd1,  32'h01,   1'b0, 3'b001},  // R6 command unarmed
    {8'd4,  MY_ID,    1'b0, 3'b000},  // R4 match
    {8'd1,  32'h01,   1'b0, 3'b010},  // R5 status
    {8'd1,  32'h01,   1'b0, 3'b001},  // R7 second command rejected
    {8'd4,  MY_ID,    1'b0, 3'b000},
    {8'd1,  32'h02,   1'b0, 3'b000},  // R5 other value ignored
    {8'd1,  32'h01,   1'b0, 3'b001},  // R7
    {8'd4,  32'h1234, 1'b0, 3'b000},  // R4 mismatch
    {8'd1,  32'h01,   1'b0, 3'b001},  // R4 unselected
    {8'd4,  MY_ID,    1'b0, 3'b000},
    {8'd48, 32'h01,   1'b0, 3'b000},  // R8 half buffer armed
    {8'd1,  32'h01,   1'b0, 3'b001},  // R8 disarmed
    {8'd4,  MY_ID,    1'b0, 3'b000},
    {8'd7,  32'h01,   1'b0, 3'b001},  // R9 malformed
    {8'd1,  32'h01,   1'b0, 3'b001},  // R9 disarmed
    {8'd4,  MY_ID,    1'b0, 3'b000},
    {8'd1,  32'h01,   1'b1, 3'b000},  // R10 busy drops status
    {8'd1,  32'h01,   1'b0, 3'b001},  // R10 state still advanced
    {8'd48, 32'h0,    1'b0, 3'b000}   // R8 half buffer unarmed
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive a frame; on return the registered outputs for it are visible.
  task automatic send_frame(input logic [7:0] len, input logic [31:0] w, input logic busy);
    @(negedge clk);
    frame_done = 1'b1; frame_len = len; payload_word = w; reply_busy = busy;
    @(negedge clk);
    frame_done = 1'b0; reply_busy = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    frame_done = 1'b0; frame_len = '0; payload_word = '0; ms_tick = 1'b0;
    reply_busy = 1'b0; fw_version = 8'h00; hw_version = 8'h00; uptime_s = '0;
    brightness = '0; frame_dur_us = '0; overruns = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_cnt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check({send_id, send_status, err_pulse, act_pulse} == 4'b0, "R1 pulses", 0, 0);
    check(bad_frames == '0, "R1 counter", longint'(bad_frames), 0);
    send_frame(8'd1, 32'h01, 1'b0);
    check(!send_status && err_pulse, "R1 unselected after reset", {send_status, err_pulse}, 2'b01);
    exp_cnt = 1;

    for (int i = 0; i < NV; i++) begin
      logic [2:0] e;
      e = VEC[i][2:0];
      send_frame(VEC[i][43:36], VEC[i][35:4], VEC[i][3]);
      if (e[0] && exp_cnt < 15) exp_cnt++;
      check(act_pulse, $sformatf("R2 act vec%0d", i), act_pulse, 1);
      check({send_id, send_status, err_pulse} == e,
            $sformatf("R4-R10 vec%0d outputs", i), {send_id, send_status, err_pulse}, e);
      check(bad_frames == CNT_W'(exp_cnt), $sformatf("R6 count vec%0d", i),
            longint'(bad_frames), exp_cnt);
      @(negedge clk);
      check(!act_pulse, $sformatf("R2 single cycle vec%0d", i), act_pulse, 0);
    end

    // R3 window closes after BOOT_WINDOW_MS ticks
    for (int t = 0; t < 99; t++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
    send_frame(8'd0, 32'h0, 1'b0);
    check(send_id, "R3 open at 99 ms", send_id, 1);
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
    send_frame(8'd0, 32'h0, 1'b0);
    check(!send_id && !err_pulse, "R3 closed at 100 ms", {send_id, err_pulse}, 0);

    // R11 saturation
    for (int k = 0; k < 12; k++) send_frame(8'd9, 32'h0, 1'b0);
    check(bad_frames == 4'hF, "R11 saturate", longint'(bad_frames), 15);
    send_frame(8'd9, 32'h0, 1'b0);
    check(err_pulse && bad_frames == 4'hF, "R11 no wrap", longint'(bad_frames), 15);

    // R12 status record
    fw_version = 8'h12; hw_version = 8'h34; uptime_s = 32'h0001_0203;
    brightness = 8'hA5; overruns = 32'h0000_0077; frame_dur_us = 32'd1000;
    @(negedge clk);
    check(status_rec == {8'h12, 8'h34, 16'h0, 32'h0001_0203, 8'hA5, 32'd1_000_000,
                         32'h77, 32'h0000_000F}, "R12 layout", status_rec[95:64], 1000000);
    frame_dur_us = 32'd0;
    @(negedge clk);
    check(status_rec[95:64] == '0, "R12 zero duration", status_rec[95:64], 0);
    frame_dur_us = 32'd16667;
    @(negedge clk);
    check(status_rec[95:64] == 32'd59998, "R12 rate", status_rec[95:64], 59998);

    // R1 reset again clears counter and selection
    send_frame(8'd4, MY_ID, 1'b0);
    do_reset();
    check(bad_frames == '0, "R1 counter cleared", longint'(bad_frames), 0);
    send_frame(8'd1, 32'h01, 1'b0);
    check(!send_status && err_pulse, "R1 selection cleared", {send_status, err_pulse}, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule